// File: doc/BRIEF.md
# Over-temperature alarm with consecutive-fault filter

This block watches a stream of temperature samples and drives one alarm pin. Each sample arrives as a 9-bit two's-complement word in half-degree units, marked by a one-cycle valid strobe. The block compares each sample against two programmable limits: an upper trip limit and a lower release (hysteresis) limit. The alarm acts only after a programmable number of consecutive samples have met the current trip condition. A single stray reading therefore never moves the pin.

Two behaviours are selectable. In comparator mode the alarm follows the temperature with hysteresis. It turns on above the upper limit and turns off below the lower limit. In interrupt mode every qualified crossing latches the alarm on, and any register-read pulse from the host clears it. The trip conditions alternate between the upper limit (rising) and the lower limit (falling).

The surrounding register file holds the configuration field and both limits. At reset it should load the limit codes 160 (80 °C) and 150 (75 °C) and a configuration of zero. The package exports these codes. Until the first conversion completes, the sensor front end simply raises no valid strobe.

Top module: `thermal_alarm`

## Requirements
- R1: While reset is low and on the cycle after it, the fault count, the direction state and the latch are clear. With configuration zero (comparator, active-low, queue 1, running), the pin is high (inactive). The package reset limit codes are 160 for the upper limit and 150 for the lower limit.
- R2: Configuration bits [4:3] select the consecutive-fault count: 00 gives 1, 01 gives 2, 10 gives 4 and 11 gives 6 samples. The alarm state changes on the clock edge that accepts the last qualifying sample and shows on the pin after that edge.
- R3: An accepted sample that fails the current trip condition resets the fault count to zero. Cycles without a valid strobe leave the count unchanged, so qualifying samples need not arrive on adjacent cycles.
- R4: In comparator mode (bit 1 = 0) the alarm turns on after the queued count of samples strictly above the upper limit. It turns off after the queued count of samples strictly below the lower limit. A sample equal to a limit is not a fault.
- R5: In interrupt mode (bit 1 = 1) the alarm stays on once latched until a cycle with the read pulse high clears it. In comparator mode the read pulse has no effect.
- R6: In interrupt mode, after a qualified rise above the upper limit, the next trip condition is the queued count below the lower limit. That crossing latches the alarm on again, and the condition then returns to the upper limit.
- R7: Configuration bit 2 sets the pin polarity: 1 drives the pin high when the alarm is on, 0 drives it low when the alarm is on.
- R8: Configuration bit 0 (shutdown) makes the block ignore samples. The fault count and the direction state hold, and the pin does not change except through a read clear.
- R9: Samples and limits compare as signed 9-bit values, so negative temperatures trip and release correctly.
- R10: In interrupt mode, if a qualifying crossing and a read pulse fall in the same cycle, the alarm ends up on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_vld | input | 1 | One-cycle strobe marking a new sample |
| smp_temp | input | 9 | Signed sample, 0.5 °C per LSB |
| cfg | input | 5 | Configuration: [4:3] queue, [2] polarity, [1] mode, [0] shutdown |
| lim_hi | input | 9 | Signed upper trip limit |
| lim_lo | input | 9 | Signed lower release limit |
| rd_pulse | input | 1 | One-cycle pulse for any host register read |
| alarm_pin | output | 1 | Alarm output at selected polarity |

## Verification
The bench builds the block with its defaults: a 9-bit sample and queue lengths 1, 2, 4 and 6. All four queue codes map to distinct counts, and the longest queue drives the counter to its largest value, 5, before an event. Directed cases cover equality at a limit, idle gaps inside a queue, negative limits, shutdown, polarity and a read colliding with a crossing. Random samples near both limits, with occasional configuration changes, then exercise mode switches in the middle of a queue against a bench model built from the requirements.

// File: rtl/thalarm_pkg.sv
// Package: shared constants and the configuration layout for the alarm.
// Assumes a 5-bit configuration field laid out as in cfg_t.
package thalarm_pkg;
    localparam int TEMP_W = 9;
    // Reset limit codes in 0.5 degree units (80 and 75 degrees).
    localparam logic [TEMP_W-1:0] RST_HI_LIM = 9'd160;
    localparam logic [TEMP_W-1:0] RST_LO_LIM = 9'd150;

    typedef struct packed {
        logic [1:0] qsel;  // consecutive-fault count select
        logic       pol;   // 1: pin active high
        logic       intr;  // 1: interrupt (latched) mode
        logic       shdn;  // 1: ignore samples
    } cfg_t;

    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction
endpackage

// File: rtl/thalarm_qdec.sv
// Queue decoder: maps the 2-bit queue select onto a consecutive count.
// Assumes every Qn parameter is at least 1 and fits in CW bits.
module thalarm_qdec #(
    parameter int Q0 = 1,
    parameter int Q1 = 2,
    parameter int Q2 = 4,
    parameter int Q3 = 6,
    parameter int CW = 3
) (
    input  logic [1:0]    qsel,
    output logic [CW-1:0] qlen
);
    localparam int QV [4] = '{Q0, Q1, Q2, Q3};
    logic [CW-1:0] tab [4];

    // Build the lookup table, one entry per select code.
    for (genvar i = 0; i < 4; i++) begin : g_tab
        assign tab[i] = CW'(QV[i]);
    end

    // Select the active queue length.
    assign qlen = tab[qsel];
endmodule

// File: rtl/thalarm_cmp.sv
// Trip comparator: tests a sample against the limit for the current direction.
// Assumes two's-complement inputs; the comparison is signed and strict.
module thalarm_cmp #(
    parameter int TW = 9
) (
    input  logic [TW-1:0] temp,
    input  logic [TW-1:0] lim_hi,
    input  logic [TW-1:0] lim_lo,
    input  logic          seek_low,
    output logic          fault
);
    logic above_hi;
    logic below_lo;

    // Signed strict comparisons against both limits.
    always_comb begin
        above_hi = $signed(temp) > $signed(lim_hi);
        below_lo = $signed(temp) < $signed(lim_lo);
    end

    // Pick the condition for the direction being watched.
    assign fault = seek_low ? below_lo : above_hi;
endmodule

// File: rtl/thalarm_fcnt.sv
// Consecutive-fault counter: counts qualifying samples and fires an event
// on the one that completes the queue. Assumes qlen >= 1.
module thalarm_fcnt #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    input  logic          fault,
    input  logic [CW-1:0] qlen,
    output logic          ev,
    output logic [CW-1:0] cnt
);
    logic hit;

    // Compare the next count with the queue, one bit wider to avoid wrap.
    assign hit = ({1'b0, cnt} + (CW+1)'(1)) >= {1'b0, qlen};
    assign ev  = adv && fault && hit;

    // Count, clear on a miss, and restart once the queue is met.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (adv) begin
            if (!fault || hit) cnt <= '0;
            else               cnt <= cnt + CW'(1);
        end
    end
endmodule

// File: rtl/thalarm_state.sv
// Alarm state: holds the watched direction and the interrupt-mode latch.
// Assumes ev is a single-cycle pulse from the fault counter.
module thalarm_state (
    input  logic clk,
    input  logic rst_n,
    input  logic ev,
    input  logic rd,
    input  logic intr,
    output logic seek_low,
    output logic latch
);
    // Flip the watched direction on every qualified crossing.
    always_ff @(posedge clk) begin
        if (!rst_n)  seek_low <= 1'b0;
        else if (ev) seek_low <= ~seek_low;
    end

    // Interrupt latch: a crossing sets it and wins over a read clear.
    always_ff @(posedge clk) begin
        if (!rst_n)            latch <= 1'b0;
        else if (ev && intr)   latch <= 1'b1;
        else if (rd && intr)   latch <= 1'b0;
    end
endmodule

// File: rtl/thermal_alarm.sv
// Top: over-temperature alarm with a consecutive-fault queue, comparator
// or latched-interrupt behaviour and selectable pin polarity.
// Assumes limits and configuration come from an outside register file.
module thermal_alarm
    import thalarm_pkg::*;
#(
    parameter int TW    = TEMP_W,
    parameter int QLEN0 = 1,
    parameter int QLEN1 = 2,
    parameter int QLEN2 = 4,
    parameter int QLEN3 = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_vld,
    input  logic [TW-1:0] smp_temp,
    input  logic [4:0]    cfg,
    input  logic [TW-1:0] lim_hi,
    input  logic [TW-1:0] lim_lo,
    input  logic          rd_pulse,
    output logic          alarm_pin
);
    localparam int QMAX = max4(QLEN0, QLEN1, QLEN2, QLEN3);
    localparam int CW   = $clog2(QMAX + 1);

    cfg_t          cf;
    logic [CW-1:0] qlen_w;
    logic [CW-1:0] cnt_w;
    logic          fault_w;
    logic          ev_w;
    logic          adv_w;
    logic          seek_q;
    logic          latch_q;
    logic          act_w;

    assign cf    = cfg_t'(cfg);
    assign adv_w = smp_vld && !cf.shdn;

    thalarm_qdec #(.Q0(QLEN0), .Q1(QLEN1), .Q2(QLEN2), .Q3(QLEN3), .CW(CW)) u_qdec (
        .qsel (cf.qsel),
        .qlen (qlen_w)
    );

    thalarm_cmp #(.TW(TW)) u_cmp (
        .temp     (smp_temp),
        .lim_hi   (lim_hi),
        .lim_lo   (lim_lo),
        .seek_low (seek_q),
        .fault    (fault_w)
    );

    thalarm_fcnt #(.CW(CW)) u_fcnt (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (adv_w),
        .fault (fault_w),
        .qlen  (qlen_w),
        .ev    (ev_w),
        .cnt   (cnt_w)
    );

    thalarm_state u_state (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev       (ev_w),
        .rd       (rd_pulse),
        .intr     (cf.intr),
        .seek_low (seek_q),
        .latch    (latch_q)
    );

    // Logical alarm per mode, then apply the pin polarity.
    assign act_w     = cf.intr ? latch_q : seek_q;
    assign alarm_pin = cf.pol ? act_w : ~act_w;
endmodule

// File: rtl/thalarm_chk.sv
// Checker: temporal properties of the alarm, bound into thermal_alarm.
module thalarm_chk #(
    parameter int CW   = 3,
    parameter int QMAX = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          smp_vld,
    input logic          shdn,
    input logic          intr,
    input logic          rd_pulse,
    input logic          ev,
    input logic [CW-1:0] cnt,
    input logic          seek_low,
    input logic          latch
);
    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        32'(cnt) < QMAX);

    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(smp_vld && !shdn) |=> $stable(cnt));

    assert_read_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        intr && rd_pulse && !ev |=> !latch);

    assert_comp_latch_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !intr |=> $stable(latch));

    assert_dir_flip_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ev |=> seek_low != $past(seek_low));

    assert_shutdown_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        shdn |=> $stable(seek_low) && $stable(cnt));

    assert_collide_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ev && intr |=> latch);
endmodule

bind thermal_alarm thalarm_chk #(.CW(CW), .QMAX(QMAX)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_vld  (smp_vld),
    .shdn     (cf.shdn),
    .intr     (cf.intr),
    .rd_pulse (rd_pulse),
    .ev       (ev_w),
    .cnt      (cnt_w),
    .seek_low (seek_q),
    .latch    (latch_q)
);

// File: tb/tb_thermal_alarm.sv
// Bench: directed corner cases plus seeded random samples, checked
// against a requirement-level model of the alarm.
module tb_thermal_alarm;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smp_vld = 1'b0;
    logic [8:0] smp_temp = '0;
    logic [4:0] cfg = '0;
    logic [8:0] lim_hi = 9'd160;
    logic [8:0] lim_lo = 9'd150;
    logic       rd_pulse = 1'b0;
    logic       alarm_pin;

    int checks = 0;
    int fails  = 0;
    int m_cnt  = 0;
    bit m_seek = 1'b0;
    bit m_latch = 1'b0;

    thermal_alarm dut (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_temp(smp_temp),
        .cfg(cfg), .lim_hi(lim_hi), .lim_lo(lim_lo), .rd_pulse(rd_pulse),
        .alarm_pin(alarm_pin)
    );

    always #2 clk = ~clk;

    function automatic int qlen_of(input logic [1:0] q);
        case (q)
            2'b00:   return 1;
            2'b01:   return 2;
            2'b10:   return 4;
            default: return 6;
        endcase
    endfunction

    function automatic bit exp_pin();
        bit act;
        act = cfg[1] ? m_latch : m_seek;
        return cfg[2] ? act : !act;
    endfunction

    task automatic check(input string tag, input bit exp);
        checks++;
        if (alarm_pin !== exp) begin
            fails++;
            $display("FAIL %s: alarm_pin=%0b expected %0b at %0t", tag, alarm_pin, exp, $time);
        end
    endtask

    // Model update for one accepted edge, from R2-R10.
    task automatic model_edge(input bit vld, input logic [8:0] t, input bit rd);
        bit cond;
        bit ev;
        ev = 1'b0;
        if (vld && !cfg[0]) begin
            cond = m_seek ? ($signed(t) < $signed(lim_lo)) : ($signed(t) > $signed(lim_hi));
            if (cond) begin
                if (m_cnt + 1 >= qlen_of(cfg[4:3])) begin ev = 1'b1; m_cnt = 0; end
                else m_cnt++;
            end else m_cnt = 0;
        end
        if (ev) m_seek = !m_seek;
        if (ev && cfg[1]) m_latch = 1'b1;
        else if (rd && cfg[1]) m_latch = 1'b0;
    endtask

    task automatic step(input bit vld, input int t, input bit rd, input string tag);
        @(negedge clk);
        smp_vld  = vld;
        smp_temp = t[8:0];
        rd_pulse = rd;
        @(posedge clk);
        #1;
        model_edge(vld, t[8:0], rd);
        check(tag, exp_pin());
        smp_vld  = 1'b0;
        rd_pulse = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        // R1: reset state with configuration zero and reset limit codes.
        repeat (3) @(posedge clk);
        #1 check("R1 in reset", 1'b1);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #1 check("R1 after reset", 1'b1);
        step(1'b0, 0, 1'b0, "R1 idle");

        // R2: queue code 10 needs 4 hot samples; active-high pin.
        cfg = 5'b10100;
        for (int i = 0; i < 4; i++) step(1'b1, 170, 1'b0, "R2 queue4 rise");
        cfg = 5'b11100;
        for (int i = 0; i < 6; i++) step(1'b1, 100, 1'b0, "R2 queue6 fall");

        // R3/R4: a sample equal to the limit resets the count; gaps hold it.
        cfg = 5'b01100;
        step(1'b1, 161, 1'b0, "R3 first");
        step(1'b1, 160, 1'b0, "R4 equal not fault");
        step(1'b1, 161, 1'b0, "R3 restart");
        step(1'b0, 0,   1'b0, "R3 gap");
        step(1'b0, 0,   1'b1, "R5 read ignored in comparator");
        step(1'b1, 161, 1'b0, "R3 gap completes");
        step(1'b1, 150, 1'b0, "R4 equal low not fault");

        // R7: polarity flip shows the same state inverted.
        cfg = 5'b01000;
        step(1'b0, 0, 1'b0, "R7 active low");

        // R8: shutdown ignores hot and cold samples.
        cfg = 5'b00101;
        for (int i = 0; i < 3; i++) step(1'b1, 0, 1'b0, "R8 shutdown");

        // R5/R6/R10: interrupt mode latch, clear and alternation.
        cfg = 5'b00110;
        step(1'b1, 100, 1'b0, "R6 low crossing latches");
        step(1'b0, 0,   1'b1, "R5 read clears");
        step(1'b1, 100, 1'b0, "R6 no retrip below");
        step(1'b1, 170, 1'b1, "R10 crossing with read");
        step(1'b0, 0,   1'b0, "R10 hold");
        step(1'b0, 0,   1'b1, "R5 read clears again");

        // R9: negative limits.
        lim_hi = 9'h1EC;  // -20 (-10 C)
        lim_lo = 9'h1D8;  // -40 (-20 C)
        cfg = 5'b00100;
        step(1'b1, -30, 1'b0, "R9 between limits");
        step(1'b1, -50, 1'b0, "R9 below negative low");
        step(1'b1, -10, 1'b0, "R9 above negative high");
        step(1'b1, -41, 1'b0, "R9 release below negative low");

        // Random phase around the reset limits.
        lim_hi = 9'd160;
        lim_lo = 9'd150;
        for (int i = 0; i < 4000; i++) begin
            if (i % 150 == 0) begin
                cfg = 5'($urandom_range(0, 31));
                if ($urandom_range(0, 3) != 0) cfg[0] = 1'b0;
            end
            step($urandom_range(0, 3) != 0, int'($urandom_range(140, 170)),
                 $urandom_range(0, 9) == 0, cfg[1] ? "R6 random" : "R4 random");
        end

        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule